// File: doc/BRIEF.md
# D-PHY Data Lane High-Speed Entry/Exit Sequencer

This block steps one D-PHY data lane through the low-power to high-speed handover and back. When a transfer is requested from idle, the lane leaves the stop state (LP-11) and passes through LP-01, LP-00 and the HS-zero preamble. It then stays in HS-data until the frame is reported done. After that it drives the HS-trail, returns to LP-11 and holds there for a minimum exit time before it accepts another request. Each phase length is a count of byte-clock periods taken from packed byte fields of two timing register words. The words are captured when a request is accepted, so software can rewrite them during a transfer without disturbing it.

Alongside the sequencer, a compliance checker compares every data-lane timing field with a minimum (and, for the prepare phase, a maximum) supplied as byte-clock counts. It raises one status bit per rule. A count of 3 at a byte-clock period of about 18.5 ns is roughly 55.6 ns, so the limit inputs are the nanosecond rules converted at the lane rate in use.

Top module: `dphy_hs_seq`

## Requirements
- R1: While reset is asserted and after it is released, the lane state reads LP-11 (code 0), busy is 0 and hs_ready is 0 until a request is accepted.
- R2: A tx_req seen in idle starts entry. The lane shows LP-01 (code 1) for TLPX cycles, then LP-00 (code 2) for PREPARE cycles, then HS-zero (code 3) for ZERO cycles, then HS-data (code 4). TLPX is timing word 0 bits [15:8]. Timing word 2 holds PREPARE in bits [7:0] and ZERO in bits [15:8].
- R3: HS-data is held until frame_done is sampled high during HS-data. A frame_done seen in any other phase has no effect.
- R4: Exit shows HS-trail (code 5) for TRAIL cycles, then LP-11 with busy still 1 for EXIT cycles, then idle LP-11 with busy 0. TRAIL is timing word 2 bits [23:16] and EXIT is timing word 0 bits [7:0].
- R5: A timing field of value 0 is treated as 1 byte-clock period, both in sequencing and in the compliance compares.
- R6: hs_ready is high for exactly one cycle: the first HS-data cycle.
- R7: Timing words are captured when a request is accepted in idle. Changes made during a transfer do not alter that transfer's phase lengths.
- R8: busy is 1 from the first LP-01 cycle through the last exit-hold cycle, and 0 otherwise.
- R9: viol is combinational on the live timing words and limits, using the effective field values from R5. bit0 is TLPX < min_lpx. bit1 is EXIT < min_exit. bit2 is PREPARE < min_prep_lo. bit3 is PREPARE > min_prep_hi. bit4 is PREPARE+ZERO < min_prep_zero. bit5 is TRAIL < min_trail.
- R10: A frame_done in the same cycle as the hs_ready strobe ends HS-data after that single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_req | input | 1 | Request to start a high-speed transfer, sampled in idle |
| frame_done | input | 1 | End of payload, sampled in HS-data |
| tim0 | input | 16 | Timing word 0: TLPX [15:8], EXIT [7:0] |
| tim2 | input | 24 | Timing word 2: TRAIL [23:16], ZERO [15:8], PREPARE [7:0] |
| min_lpx | input | 8 | Minimum TLPX count |
| min_exit | input | 8 | Minimum EXIT count |
| min_prep_lo | input | 8 | Minimum PREPARE count |
| min_prep_hi | input | 8 | Maximum PREPARE count |
| min_prep_zero | input | 9 | Minimum PREPARE+ZERO count |
| min_trail | input | 8 | Minimum TRAIL count |
| lane_state | output | 3 | Encoded lane state, codes 0 to 5 |
| hs_ready | output | 1 | One-cycle strobe at the start of HS-data |
| busy | output | 1 | Transfer in progress, including exit hold |
| viol | output | 6 | Compliance violation bits |

## Verification
The hs_ready strobe and the acceptance of frame_done can fall in the same cycle, which is the first HS-data cycle. The bench raises frame_done exactly then on a share of the swept transfers. It expects HS-data to last one cycle with the strobe present, and HS-trail to follow on the next cycle. The bench also presents a stray frame_done during LP-00 and overwrites the timing words during LP-01 in the same transfers. This shows that neither is taken up by the running sequence.

// File: rtl/dphy_seq_pkg.sv
package dphy_seq_pkg;
  localparam int FIELD_W = 8;
  localparam int NUM_RULES = 6;

  typedef enum logic [2:0] {
    LN_LP11    = 3'd0,
    LN_LP01    = 3'd1,
    LN_LP00    = 3'd2,
    LN_HSZERO  = 3'd3,
    LN_HSDATA  = 3'd4,
    LN_HSTRAIL = 3'd5
  } lane_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LPX, ST_PREP, ST_ZERO, ST_DATA, ST_TRAIL, ST_EXIT
  } seq_e;

  typedef struct packed {
    logic [FIELD_W-1:0] lpx;
    logic [FIELD_W-1:0] exit_t;
    logic [FIELD_W-1:0] prep;
    logic [FIELD_W-1:0] zero;
    logic [FIELD_W-1:0] trail;
  } phase_t;
endpackage

// File: rtl/dphy_field_unpack.sv
module dphy_field_unpack
  import dphy_seq_pkg::*;
(
  input  logic [2*FIELD_W-1:0] tim0,
  input  logic [3*FIELD_W-1:0] tim2,
  output phase_t               eff
);
  localparam int NF = 5;
  logic [FIELD_W-1:0] raw [NF];
  logic [FIELD_W-1:0] fix [NF];

  assign raw[0] = tim0[2*FIELD_W-1:FIELD_W];
  assign raw[1] = tim0[FIELD_W-1:0];
  assign raw[2] = tim2[FIELD_W-1:0];
  assign raw[3] = tim2[2*FIELD_W-1:FIELD_W];
  assign raw[4] = tim2[3*FIELD_W-1:2*FIELD_W];

  // zero count is lifted to one period so no phase vanishes
  for (genvar g = 0; g < NF; g++) begin : g_clamp
    assign fix[g] = (raw[g] == '0) ? FIELD_W'(1) : raw[g];
  end

  assign eff.lpx    = fix[0];
  assign eff.exit_t = fix[1];
  assign eff.prep   = fix[2];
  assign eff.zero   = fix[3];
  assign eff.trail  = fix[4];
endmodule

// File: rtl/dphy_compliance.sv
module dphy_compliance
  import dphy_seq_pkg::*;
(
  input  phase_t             eff,
  input  logic [FIELD_W-1:0] min_lpx,
  input  logic [FIELD_W-1:0] min_exit,
  input  logic [FIELD_W-1:0] min_prep_lo,
  input  logic [FIELD_W-1:0] min_prep_hi,
  input  logic [FIELD_W:0]   min_prep_zero,
  input  logic [FIELD_W-1:0] min_trail,
  output logic [NUM_RULES-1:0] viol
);
  logic [FIELD_W:0] prep_zero;

  always_comb begin
    prep_zero = {1'b0, eff.prep} + {1'b0, eff.zero};
    viol[0]   = eff.lpx    < min_lpx;
    viol[1]   = eff.exit_t < min_exit;
    viol[2]   = eff.prep   < min_prep_lo;
    viol[3]   = eff.prep   > min_prep_hi;
    viol[4]   = prep_zero  < min_prep_zero;
    viol[5]   = eff.trail  < min_trail;
  end
endmodule

// File: rtl/dphy_hs_seq.sv
module dphy_hs_seq
  import dphy_seq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tx_req,
  input  logic                 frame_done,
  input  logic [15:0]          tim0,
  input  logic [23:0]          tim2,
  input  logic [7:0]           min_lpx,
  input  logic [7:0]           min_exit,
  input  logic [7:0]           min_prep_lo,
  input  logic [7:0]           min_prep_hi,
  input  logic [8:0]           min_prep_zero,
  input  logic [7:0]           min_trail,
  output logic [2:0]           lane_state,
  output logic                 hs_ready,
  output logic                 busy,
  output logic [5:0]           viol
);
  localparam int SYNC_STAGES = 2;

  // reset: asserted at once, released through a short flop chain
  logic [SYNC_STAGES-1:0] rst_sync;
  logic                   rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_i_n = rst_sync[SYNC_STAGES-1];

  phase_t live_eff;
  phase_t shadow_q;

  dphy_field_unpack u_unpack (
    .tim0 (tim0),
    .tim2 (tim2),
    .eff  (live_eff)
  );

  dphy_compliance u_check (
    .eff           (live_eff),
    .min_lpx       (min_lpx),
    .min_exit      (min_exit),
    .min_prep_lo   (min_prep_lo),
    .min_prep_hi   (min_prep_hi),
    .min_prep_zero (min_prep_zero),
    .min_trail     (min_trail),
    .viol          (viol)
  );

  seq_e               state_q, state_d;
  logic [FIELD_W-1:0] cnt_q, cnt_d;
  logic               shadow_en;
  logic               rdy_q, rdy_d;

  // next-state process
  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    shadow_en = 1'b0;
    rdy_d     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (tx_req) begin
        shadow_en = 1'b1;
        state_d   = ST_LPX;
        cnt_d     = live_eff.lpx - FIELD_W'(1);
      end
      ST_LPX: if (cnt_q == '0) begin
        state_d = ST_PREP;
        cnt_d   = shadow_q.prep - FIELD_W'(1);
      end else cnt_d = cnt_q - FIELD_W'(1);
      ST_PREP: if (cnt_q == '0) begin
        state_d = ST_ZERO;
        cnt_d   = shadow_q.zero - FIELD_W'(1);
      end else cnt_d = cnt_q - FIELD_W'(1);
      ST_ZERO: if (cnt_q == '0) begin
        state_d = ST_DATA;
        rdy_d   = 1'b1;
      end else cnt_d = cnt_q - FIELD_W'(1);
      ST_DATA: if (frame_done) begin
        state_d = ST_TRAIL;
        cnt_d   = shadow_q.trail - FIELD_W'(1);
      end
      ST_TRAIL: if (cnt_q == '0) begin
        state_d = ST_EXIT;
        cnt_d   = shadow_q.exit_t - FIELD_W'(1);
      end else cnt_d = cnt_q - FIELD_W'(1);
      ST_EXIT: if (cnt_q == '0) state_d = ST_IDLE;
               else cnt_d = cnt_q - FIELD_W'(1);
      default: state_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      rdy_q   <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)       shadow_q <= '0;
    else if (shadow_en) shadow_q <= live_eff;
  end

  // lane encoding
  always_comb begin
    unique case (state_q)
      ST_LPX:   lane_state = LN_LP01;
      ST_PREP:  lane_state = LN_LP00;
      ST_ZERO:  lane_state = LN_HSZERO;
      ST_DATA:  lane_state = LN_HSDATA;
      ST_TRAIL: lane_state = LN_HSTRAIL;
      default:  lane_state = LN_LP11;
    endcase
  end

  assign busy     = (state_q != ST_IDLE);
  assign hs_ready = rdy_q;

  // R6
  hs_ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    hs_ready |=> !hs_ready);

  // R6
  hs_ready_place_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    hs_ready |-> (lane_state == LN_HSDATA) && ($past(lane_state) == LN_HSZERO));

  // R2
  lp01_entry_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lane_state == LN_LP01) |->
      ($past(lane_state) == LN_LP11 || $past(lane_state) == LN_LP01));

  // R3
  data_leave_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($past(lane_state) == LN_HSDATA && lane_state != LN_HSDATA) |-> $past(frame_done));

  // R4
  trail_entry_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    (lane_state == LN_HSTRAIL) |->
      ($past(lane_state) == LN_HSDATA || $past(lane_state) == LN_HSTRAIL));

  // R8
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    $rose(busy) |-> (lane_state == LN_LP01));
endmodule

// File: tb/dphy_hs_seq_test.sv
module dphy_hs_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        tx_req, frame_done;
  logic [15:0] tim0;
  logic [23:0] tim2;
  logic [7:0]  min_lpx, min_exit, min_prep_lo, min_prep_hi, min_trail;
  logic [8:0]  min_prep_zero;
  logic [2:0]  lane_state;
  logic        hs_ready, busy;
  logic [5:0]  viol;

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #10 clk = ~clk;

  dphy_hs_seq uut (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .frame_done(frame_done),
    .tim0(tim0), .tim2(tim2), .min_lpx(min_lpx), .min_exit(min_exit),
    .min_prep_lo(min_prep_lo), .min_prep_hi(min_prep_hi),
    .min_prep_zero(min_prep_zero), .min_trail(min_trail),
    .lane_state(lane_state), .hs_ready(hs_ready), .busy(busy), .viol(viol)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int ef(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  // expect n cycles of a lane code; checks at negedge, then steps one negedge
  task automatic phase(input string req, input int code, input int bsy, input int n);
    for (int i = 0; i < n; i++) begin
      chk({req, " lane"}, lane_state, code);
      chk("R8 busy", busy, bsy);
      chk("R6 hs_ready", hs_ready, 0);
      @(negedge clk);
    end
  endtask

  task automatic xfer(input int lpx, input int ex, input int prep, input int zero,
                      input int trail, input int fd);
    tim0 = 16'((lpx << 8) | ex);
    tim2 = 24'((trail << 16) | (zero << 8) | prep);
    tx_req = 1'b1;
    @(negedge clk);
    tx_req = 1'b0;
    // R7: scramble the words during the transfer
    tim0 = 16'hFFFF;
    tim2 = 24'hFFFFFF;
    phase("R2 lp01", 1, 1, ef(lpx));
    // R3: stray frame_done during LP-00 must be ignored
    frame_done = 1'b1;
    phase("R2 lp00", 2, 1, 1);
    frame_done = 1'b0;
    phase("R2 lp00", 2, 1, ef(prep) - 1);
    phase("R2 hszero", 3, 1, ef(zero));
    for (int i = 0; i <= fd; i++) begin
      chk("R3 hsdata lane", lane_state, 4);
      chk("R6 hs_ready", hs_ready, (i == 0) ? 1 : 0);
      chk("R8 busy", busy, 1);
      frame_done = (i == fd);
      @(negedge clk);
    end
    frame_done = 1'b0;
    phase(fd == 0 ? "R10 trail" : "R4 trail", 5, 1, ef(trail));
    phase("R4 exit", 0, 1, ef(ex));
    chk("R4 idle lane", lane_state, 0);
    chk("R8 idle busy", busy, 0);
  endtask

  initial begin
    rst_n = 1'b0; tx_req = 1'b0; frame_done = 1'b0;
    tim0 = 16'h0306; tim2 = 24'h040A03;
    min_lpx = 8'd3; min_exit = 8'd5; min_prep_lo = 8'd2; min_prep_hi = 8'd4;
    min_prep_zero = 9'd8; min_trail = 8'd3;
    repeat (3) @(negedge clk);
    chk("R1 reset lane", lane_state, 0);
    chk("R1 reset busy", busy, 0);
    chk("R1 reset hs_ready", hs_ready, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 post lane", lane_state, 0);
    chk("R1 post busy", busy, 0);
    // R3: frame_done in idle does nothing
    frame_done = 1'b1;
    @(negedge clk);
    frame_done = 1'b0;
    chk("R3 idle fd lane", lane_state, 0);
    chk("R3 idle fd busy", busy, 0);

    // sweep of phase lengths; R5 covered by zero values, R10 by fd==0
    for (int a = 0; a < 4; a++)
      for (int p = 0; p < 4; p++)
        for (int z = 0; z < 4; z++)
          for (int t = 0; t < 3; t++)
            for (int e = 0; e < 3; e++)
              xfer(a, e, p, z, t, (a + p + z + t + e) % 3);

    // R9: compliance bits, idle, live words
    for (int i = 0; i < 216; i++) begin
      int l, e, p, z, t, exp;
      l = i % 6; e = (i / 6) % 6; p = (i / 36) % 6; z = (i + 1) % 6; t = (i + 2) % 6;
      tim0 = 16'((l << 8) | e);
      tim2 = 24'((t << 16) | (z << 8) | p);
      #1;
      exp = ((ef(l) < 3) ? 1 : 0) | ((ef(e) < 5) ? 2 : 0) | ((ef(p) < 2) ? 4 : 0)
          | ((ef(p) > 4) ? 8 : 0) | ((ef(p) + ef(z) < 8) ? 16 : 0) | ((ef(t) < 3) ? 32 : 0);
      chk("R9 viol", viol, exp);
      @(negedge clk);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule